// File: doc/BRIEF.md
# UART interrupt identification logic

This block gathers every interrupt condition of a 16550-compatible serial port, ranks them, and presents the most urgent one in an eight-bit identification byte that the host reads. It also drives the single interrupt line to the host and runs the receive character-timeout counter, which advances on a character-time tick from the baud logic. The FIFO storage, the shift registers and the baud generator sit outside and supply level flags and single-cycle strobes.

Line-status and modem-status conditions arrive as event pulses and are held until their own status register is read. Receive-data availability is a level. Transmit-empty is latched on the rising edge of the holding-register-empty flag. The host's register-read strobe for the identification byte freezes the byte for as long as the strobe stays high. The first cycle of such a read clears a transmit-empty condition that is being reported, and the block pulses `thre_ack` in that cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst_n` is low and right after reset, `iir` reads 0x01, `irq` is 0 and `thre_ack` is 0.
- R2: Among enabled pending sources the reported code in `iir[3:1]` follows the ranking line status (011) over receive data (010) over character timeout (110) over transmit empty (001) over modem status (000). Receive data and timeout share a rank, and receive data wins a tie.
- R3: `iir[0]` is 0 when some enabled source is pending and 1 otherwise, so an idle block reads 0001 in `iir[3:0]`.
- R4: `iir[7]` and `iir[6]` both equal `fifo_en`, and `iir[5:4]` is always 0.
- R5: With `fifo_en` low the timeout counter holds at zero, code 110 never appears and `iir[3]` is 0.
- R6: While `iir_rd` is high `iir` keeps the value it had when the read began. Conditions that change during the read show up in the cycle after `iir_rd` falls.
- R7: A pulse on any bit of `lsr_evt` (overrun, parity, framing, break) sets the line-status source, and `lsr_rd` clears it.
- R8: The receive-data source follows `rx_trig` in FIFO mode and `rx_avail` otherwise. It drops as soon as that level drops.
- R9: In FIFO mode, with `rx_nonempty` high, the timeout source fires on the fourth `char_tick` with no `rx_push` or `rx_pop`. A push or pop restarts the count and a pop clears a fired timeout. An empty FIFO holds the count at zero.
- R10: A rising edge of `thr_empty` sets the transmit-empty source. `thr_wr` clears it. So does the first cycle of an `iir_rd` access while code 001 is shown, and `thre_ack` pulses high in that cycle only.
- R11: A pulse on any bit of `msr_evt` (delta CTS, delta DSR, ring trailing edge, delta DCD) sets the modem-status source, and `msr_rd` clears it.
- R12: `irq_en` bit 0 enables receive data and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. A disabled source is neither reported nor drives `irq`, and `irq` is the OR of the enabled pending sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| irq_en | input | 4 | Per-source enables (see R12) |
| lsr_evt | input | 4 | Line error event pulses |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_avail | input | 1 | Receive data ready level (non-FIFO) |
| rx_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | Character written into receive FIFO |
| rx_pop | input | 1 | Receive buffer read |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | Transmit buffer write strobe |
| msr_evt | input | 4 | Modem status delta event pulses |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_rd | input | 1 | Identification register read, high during the access |
| iir | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request |
| thre_ack | output | 1 | Transmit-empty cleared by identification read |

## Verification
Sources are raised one at a time on top of each other, so each new code shows that the ranking lets the higher source through. They are then retired in reverse order, which shows the lower sources were still held underneath. A read that overlaps a new line error separates the frozen byte from the live one and shows the read-clear of transmit empty. Tick runs with and without a push in the middle, and with the FIFO emptied, show the four-tick boundary, the restart and the empty hold. Repeating the receive and tick patterns with FIFO mode off, and raising sources with their enables low, shows that the mode and the mask gate what is reported.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef struct packed {
        logic ls;
        logic rda;
        logic cto;
        logic te;
        logic ms;
    } irq_pend_t;

    localparam logic [2:0] ID_LS  = 3'b011;
    localparam logic [2:0] ID_RDA = 3'b010;
    localparam logic [2:0] ID_CTO = 3'b110;
    localparam logic [2:0] ID_TE  = 3'b001;
    localparam logic [2:0] ID_MS  = 3'b000;

    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;
    localparam int EN_W  = 4;

endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
    parameter int TO_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic nonempty,
    input  logic push,
    input  logic pop,
    input  logic tick,
    output logic hit_d
);
    localparam int CNT_W = $clog2(TO_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TO_TICKS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!enable || !nonempty || push || pop) begin
            cnt_d = '0;
        end else if (tick && cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
        hit_d = (cnt_d == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_pend_t       pend,
    input  logic [EN_W-1:0] en,
    input  logic            fifo_en,
    output logic [7:0]      id_byte,
    output logic            any
);
    irq_pend_t live;
    logic [2:0] code;

    always_comb begin
        live.ls  = pend.ls  & en[EN_LS];
        live.rda = pend.rda & en[EN_RX];
        live.cto = pend.cto & en[EN_RX] & fifo_en;
        live.te  = pend.te  & en[EN_TX];
        live.ms  = pend.ms  & en[EN_MS];
        any = |live;

        if (live.ls)       code = ID_LS;
        else if (live.rda) code = ID_RDA;
        else if (live.cto) code = ID_CTO;
        else if (live.te)  code = ID_TE;
        else               code = ID_MS;

        id_byte = {fifo_en, fifo_en, 2'b00, code, ~any};
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int TO_TICKS = 4,
    parameter int LS_W     = 4,
    parameter int MS_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_en,
    input  logic [EN_W-1:0] irq_en,
    input  logic [LS_W-1:0] lsr_evt,
    input  logic            lsr_rd,
    input  logic            rx_avail,
    input  logic            rx_trig,
    input  logic            rx_nonempty,
    input  logic            rx_push,
    input  logic            rx_pop,
    input  logic            char_tick,
    input  logic            thr_empty,
    input  logic            thr_wr,
    input  logic [MS_W-1:0] msr_evt,
    input  logic            msr_rd,
    input  logic            iir_rd,
    output logic [7:0]      iir,
    output logic            irq,
    output logic            thre_ack
);
    localparam logic [3:0] TE_SHOWN = {ID_TE, 1'b0};

    typedef struct packed {
        logic       thr_prev;
        logic       rd_prev;
        logic       irq;
        logic [7:0] iir;
    } ctl_t;

    irq_pend_t pend_d, pend_q;
    ctl_t      ctl_d, ctl_q;
    logic      cto_hit;
    logic [7:0] live_iir;
    logic      live_any;

    uart_irq_timeout #(.TO_TICKS(TO_TICKS)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (fifo_en),
        .nonempty (rx_nonempty),
        .push     (rx_push),
        .pop      (rx_pop),
        .tick     (char_tick),
        .hit_d    (cto_hit)
    );

    uart_irq_prio u_prio (
        .pend    (pend_d),
        .en      (irq_en),
        .fifo_en (fifo_en),
        .id_byte (live_iir),
        .any     (live_any)
    );

    assign thre_ack = iir_rd && !ctl_q.rd_prev && (ctl_q.iir[3:0] == TE_SHOWN);

    // Next pending state of every source.
    always_comb begin
        pend_d     = pend_q;
        pend_d.ls  = (|lsr_evt) | (pend_q.ls & ~lsr_rd);
        pend_d.rda = fifo_en ? rx_trig : rx_avail;
        pend_d.cto = cto_hit;
        pend_d.te  = (thr_empty & ~ctl_q.thr_prev)
                   | (pend_q.te & ~(thr_wr | thre_ack));
        pend_d.ms  = (|msr_evt) | (pend_q.ms & ~msr_rd);
    end

    // Visible register, frozen for the duration of a read.
    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.thr_prev = thr_empty;
        ctl_d.rd_prev  = iir_rd;
        ctl_d.irq      = live_any;
        ctl_d.iir      = iir_rd ? ctl_q.iir : live_iir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            ctl_q  <= '{thr_prev: 1'b0, rd_prev: 1'b0, irq: 1'b0, iir: 8'h01};
        end else begin
            pend_q <= pend_d;
            ctl_q  <= ctl_d;
        end
    end

    assign iir = ctl_q.iir;
    assign irq = ctl_q.irq;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic [3:0] irq_en,
    input logic       rx_pop,
    input logic       iir_rd,
    input logic [7:0] iir,
    input logic       irq,
    input logic       thre_ack
);
    a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (iir[7] == iir[6]) && (iir[5:4] == 2'b00));

    a_r5_no_fifo_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (!iir_rd && !fifo_en) |=> (iir[7:3] == 5'b00000));

    a_r6_frozen_read: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd |=> $stable(iir));

    a_r9_pop_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !iir_rd) |=> !(iir[3:0] == 4'b1100));

    a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        thre_ack |=> !thre_ack);

    a_r10_ack_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        thre_ack |-> iir_rd);

    a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'b0000) |=> !irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .irq_en   (irq_en),
    .rx_pop   (rx_pop),
    .iir_rd   (iir_rd),
    .iir      (iir),
    .irq      (irq),
    .thre_ack (thre_ack)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [3:0] irq_en = 4'hF;
    logic [3:0] lsr_evt = '0;
    logic       lsr_rd = 1'b0;
    logic       rx_avail = 1'b0, rx_trig = 1'b0, rx_nonempty = 1'b0;
    logic       rx_push = 1'b0, rx_pop = 1'b0, char_tick = 1'b0;
    logic       thr_empty = 1'b0, thr_wr = 1'b0;
    logic [3:0] msr_evt = '0;
    logic       msr_rd = 1'b0, iir_rd = 1'b0;
    logic [7:0] iir;
    logic       irq, thre_ack;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] iir;
        logic       irq;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .irq_en(irq_en),
        .lsr_evt(lsr_evt), .lsr_rd(lsr_rd), .rx_avail(rx_avail),
        .rx_trig(rx_trig), .rx_nonempty(rx_nonempty), .rx_push(rx_push),
        .rx_pop(rx_pop), .char_tick(char_tick), .thr_empty(thr_empty),
        .thr_wr(thr_wr), .msr_evt(msr_evt), .msr_rd(msr_rd),
        .iir_rd(iir_rd), .iir(iir), .irq(irq), .thre_ack(thre_ack)
    );

    task automatic check_bit(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Driver: inputs already set at a negedge; one clock, then record expectation.
    task automatic step(input logic [7:0] e_iir, input logic e_irq, input string req);
        exp_t it;
        @(posedge clk);
        it.iir = e_iir; it.irq = e_irq; it.req = req;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compare after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                total++;
                if (iir !== it.iir || irq !== it.irq) begin
                    bad++;
                    $display("FAIL %s: got iir=%h irq=%b expected iir=%h irq=%b",
                             it.req, iir, irq, it.iir, it.irq);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (iir !== 8'h01 || irq !== 1'b0 || thre_ack !== 1'b0) begin
            bad++;
            $display("FAIL R1: got iir=%h irq=%b ack=%b expected 01 0 0", iir, irq, thre_ack);
        end
        rst_n = 1'b1;
        step(8'h01, 1'b0, "R1 idle after reset");

        fifo_en = 1'b1;
        step(8'hC1, 1'b0, "R4 fifo bits R3 idle");

        msr_evt = 4'b0001; step(8'hC0, 1'b1, "R11 modem set");
        msr_evt = 4'b0000; step(8'hC0, 1'b1, "R11 modem held");
        thr_empty = 1'b1;  step(8'hC2, 1'b1, "R10 tx empty over modem R2");
        rx_trig = 1'b1;    step(8'hC4, 1'b1, "R8 rx trig R2");
        lsr_evt = 4'b0100; step(8'hC6, 1'b1, "R7 line status R2");
        lsr_evt = 4'b0000;
        lsr_rd = 1'b1;     step(8'hC4, 1'b1, "R7 lsr read clears");
        lsr_rd = 1'b0;
        rx_trig = 1'b0;    step(8'hC2, 1'b1, "R8 rx trig drop");

        // Read while tx empty shown, with a new line error arriving.
        iir_rd = 1'b1; lsr_evt = 4'b1000;
        #1 check_bit(thre_ack, 1'b1, "R10 ack on read start");
        step(8'hC2, 1'b1, "R6 frozen first cycle");
        lsr_evt = 4'b0000;
        #1 check_bit(thre_ack, 1'b0, "R10 ack single pulse");
        step(8'hC2, 1'b1, "R6 frozen second cycle");
        iir_rd = 1'b0;   step(8'hC6, 1'b1, "R6 change after read");
        lsr_rd = 1'b1;   step(8'hC0, 1'b1, "R10 tx empty cleared by read");
        lsr_rd = 1'b0;
        msr_rd = 1'b1;   step(8'hC1, 1'b0, "R11 msr read clears");
        msr_rd = 1'b0;

        // Character timeout.
        rx_nonempty = 1'b1; rx_avail = 1'b1;
        char_tick = 1'b1;
        step(8'hC1, 1'b0, "R9 tick1 R8 avail ignored in fifo");
        step(8'hC1, 1'b0, "R9 tick2");
        step(8'hC1, 1'b0, "R9 tick3");
        step(8'hCC, 1'b1, "R9 tick4 fires");
        char_tick = 1'b0;
        rx_pop = 1'b1;  step(8'hC1, 1'b0, "R9 pop clears");
        rx_pop = 1'b0;
        char_tick = 1'b1;
        step(8'hC1, 1'b0, "R9 tick1");
        step(8'hC1, 1'b0, "R9 tick2");
        rx_push = 1'b1; step(8'hC1, 1'b0, "R9 push restarts");
        rx_push = 1'b0;
        step(8'hC1, 1'b0, "R9 after push tick1");
        step(8'hC1, 1'b0, "R9 after push tick2");
        step(8'hC1, 1'b0, "R9 after push tick3");
        step(8'hCC, 1'b1, "R9 after push tick4");
        char_tick = 1'b0;
        rx_trig = 1'b1; step(8'hC4, 1'b1, "R2 data wins tie over timeout");
        rx_trig = 1'b0; step(8'hCC, 1'b1, "R2 timeout remains");
        rx_nonempty = 1'b0; step(8'hC1, 1'b0, "R9 empty holds zero");

        // Non-FIFO mode.
        fifo_en = 1'b0;
        step(8'h04, 1'b1, "R8 avail in non-fifo R4");
        rx_nonempty = 1'b1; char_tick = 1'b1;
        for (int i = 0; i < 5; i++) step(8'h04, 1'b1, "R5 ticks without fifo");
        char_tick = 1'b0;
        rx_avail = 1'b0; step(8'h01, 1'b0, "R5 no timeout code");
        rx_nonempty = 1'b0;

        // Enable mask.
        irq_en = 4'b0000;
        msr_evt = 4'b0010; step(8'h01, 1'b0, "R12 masked modem");
        msr_evt = 4'b0000;
        irq_en = 4'b1000;  step(8'h00, 1'b1, "R12 unmasked modem");
        msr_rd = 1'b1;     step(8'h01, 1'b0, "R11 clear");
        msr_rd = 1'b0;
        irq_en = 4'hF;

        // Tx empty cleared by write; read with nothing shown.
        thr_empty = 1'b0; step(8'h01, 1'b0, "R10 no rise");
        thr_empty = 1'b1; step(8'h02, 1'b1, "R10 rise sets");
        thr_wr = 1'b1;    step(8'h01, 1'b0, "R10 write clears");
        thr_wr = 1'b0;
        iir_rd = 1'b1;
        #1 check_bit(thre_ack, 1'b0, "R10 no ack when not shown");
        step(8'h01, 1'b0, "R3 idle read");
        iir_rd = 1'b0;
        step(8'h01, 1'b0, "R3 idle");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule